// File: doc/BRIEF.md
# Bus Memory Aperture Mapper

This block sits on an 8-bit microcomputer expansion bus with a 16-bit address and a single-phase CPU clock of roughly 1.8 MHz. It keeps a table of sixteen memory windows, each of which maps a run of 256-byte host pages onto a 32-bit linear address in external PSRAM. On each bus cycle it samples the address a fixed number of fast clocks after the CPU clock falls. If the address lies in an enabled window, it pulls the active-low memory-override strobe low and presents the translated PSRAM address together with a read or write qualifier.

Software sets up the windows by writing bytes into the block's I/O page at $D1xx, and it can read them back there. A write to the command byte at $D180 produces a one-clock strobe that carries the written value, so a later engine can start an operation once software has loaded its arguments. Addresses that the system's device-select scheme shares ($D100, $D101, $D1FF) are never answered, and neither is anything from $D181 upward.

Top module: `bus_aperture_map`

## Requirements
- R1: After reset every window is disabled (all table bytes zero), the override strobe is high, and the PSRAM read/write qualifiers and the host data enable are low.
- R2: Window i occupies host addresses $D100+8i to $D100+8i+7. Byte 0 is the least significant and byte 3 the most significant byte of the 32-bit PSRAM base, byte 4 is the first host page (address bits 15:8), byte 5 is the page count, byte 6 is the line stride in pages, and byte 7 is spare storage. A host write is stored at the end of its bus cycle, and it governs mapping from the next bus cycle on.
- R3: A host read of $D102 to $D17F asserts the host data enable and returns the stored byte.
- R4: Writes to $D100, $D101 and $D181 to $D1FF change nothing, and reads there leave the host data enable low. Bits 15:0 of window 0's base therefore always read as zero.
- R5: An address outside page $D1 hits window i when its count is nonzero and start <= A[15:8] < start + count. On a hit the override strobe goes low. Otherwise it stays high.
- R6: On a hit, the PSRAM address equals base + ((A[15:8] - start) << 8) + A[7:0].
- R7: On a hit, psram_rd is high for a read (R/W = 1) and psram_wr is high for a write (R/W = 0). Exactly one of them is high during a hit, and neither is high without a hit.
- R8: When several windows match, the window with the lowest index is used.
- R9: No address in page $D1 ever produces a hit, including $D1FF, even when a window's range covers that page.
- R10: A host write to $D180 produces, at the end of that bus cycle, a cmd_strobe pulse exactly one fast clock long, with cmd_byte holding the written byte.
- R11: The outputs return to idle within a few fast clocks after the CPU clock falls. They take the new cycle's values SETTLE_CYC+1 fast clocks after the synchronized falling edge and hold them until the next fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast FPGA clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_phi2 | input | 1 | CPU bus clock (asynchronous) |
| bus_rw | input | 1 | Bus R/W, 1 = read |
| bus_addr | input | 16 | Bus address |
| bus_data | input | 8 | Bus data, sampled for host writes |
| mpd_n | output | 1 | Active-low memory-override strobe |
| psram_addr | output | 32 | Translated PSRAM address |
| psram_rd | output | 1 | PSRAM read qualifier |
| psram_wr | output | 1 | PSRAM write qualifier |
| host_data_oe | output | 1 | Enable to drive host_rd_data onto the bus |
| host_rd_data | output | 8 | Table byte returned for a host read |
| cmd_strobe | output | 1 | One-clock command pulse |
| cmd_byte | output | 8 | Command value written to $D180 |

## Verification
The checker tests on every cycle the relations that must hold among the outputs. The qualifiers agree with the override strobe and are mutually exclusive, a mapped access never drives host data, the command pulse lasts one clock, the PSRAM address holds steady while a hit lasts, and everything is idle right after reset. Other properties need a reference table that the scoreboard bench keeps: that the right window is chosen, the translated address value, the range end points, that a window ignores writes to locked or unused addresses, that read-back is correct, and that an updated descriptor governs the very next bus cycle.

// File: rtl/ap_pkg.sv
package ap_pkg;
  localparam int DESC_BYTES = 8;

  typedef struct packed {
    logic [7:0]  spare;
    logic [7:0]  stride;
    logic [7:0]  count;
    logic [7:0]  start;
    logic [31:0] base;
  } ap_desc_t;
endpackage

// File: rtl/ap_bus_sync.sv
module ap_bus_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    st[0] <= d;
    for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/ap_desc_table.sv
module ap_desc_table
  import ap_pkg::*;
#(
  parameter int N_AP = 16,
  localparam int OFS_W = $clog2(N_AP*DESC_BYTES),
  localparam int IDX_W = OFS_W - 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [OFS_W-1:0] wr_ofs,
  input  logic [7:0]       wr_byte,
  input  logic [OFS_W-1:0] rd_ofs,
  output logic [7:0]       rd_byte,
  output ap_desc_t         desc_o [N_AP]
);
  ap_desc_t regs [N_AP];

  for (genvar i = 0; i < N_AP; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) begin
        regs[i] <= '0;
      end else if (wr_en && wr_ofs[OFS_W-1:3] == IDX_W'(i)) begin
        case (wr_ofs[2:0])
          3'd0: regs[i].base[7:0]   <= wr_byte;
          3'd1: regs[i].base[15:8]  <= wr_byte;
          3'd2: regs[i].base[23:16] <= wr_byte;
          3'd3: regs[i].base[31:24] <= wr_byte;
          3'd4: regs[i].start       <= wr_byte;
          3'd5: regs[i].count       <= wr_byte;
          3'd6: regs[i].stride      <= wr_byte;
          default: regs[i].spare    <= wr_byte;
        endcase
      end
    end
    assign desc_o[i] = regs[i];
  end

  ap_desc_t rsel;
  always_comb begin
    rsel = regs[rd_ofs[OFS_W-1:3]];
    case (rd_ofs[2:0])
      3'd0: rd_byte = rsel.base[7:0];
      3'd1: rd_byte = rsel.base[15:8];
      3'd2: rd_byte = rsel.base[23:16];
      3'd3: rd_byte = rsel.base[31:24];
      3'd4: rd_byte = rsel.start;
      3'd5: rd_byte = rsel.count;
      3'd6: rd_byte = rsel.stride;
      default: rd_byte = rsel.spare;
    endcase
  end
endmodule

// File: rtl/ap_window_match.sv
module ap_window_match
  import ap_pkg::*;
#(
  parameter int N_AP = 16
) (
  input  ap_desc_t    desc_i [N_AP],
  input  logic [7:0]  page,
  input  logic [7:0]  low,
  output logic        hit,
  output logic [31:0] xlat
);
  logic [7:0]      off   [N_AP];
  logic [N_AP-1:0] in_rng;

  for (genvar i = 0; i < N_AP; i++) begin : g_cmp
    assign off[i]    = page - desc_i[i].start;
    assign in_rng[i] = (desc_i[i].count != 8'd0) && (page >= desc_i[i].start)
                       && (off[i] < desc_i[i].count);
  end

  logic [31:0] base_sel;
  logic [7:0]  off_sel;
  always_comb begin
    hit      = 1'b0;
    base_sel = '0;
    off_sel  = '0;
    for (int i = N_AP-1; i >= 0; i--) begin
      if (in_rng[i]) begin
        hit      = 1'b1;
        base_sel = desc_i[i].base;
        off_sel  = off[i];
      end
    end
  end

  assign xlat = base_sel + {16'd0, off_sel, low};
endmodule

// File: rtl/bus_aperture_map.sv
module bus_aperture_map
  import ap_pkg::*;
#(
  parameter int         N_AP        = 16,
  parameter logic [7:0] IO_PAGE     = 8'hD1,
  parameter logic [7:0] CMD_OFS     = 8'h80,
  parameter int         SETTLE_CYC  = 16,
  parameter int         SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_phi2,
  input  logic        bus_rw,
  input  logic [15:0] bus_addr,
  input  logic [7:0]  bus_data,
  output logic        mpd_n,
  output logic [31:0] psram_addr,
  output logic        psram_rd,
  output logic        psram_wr,
  output logic        host_data_oe,
  output logic [7:0]  host_rd_data,
  output logic        cmd_strobe,
  output logic [7:0]  cmd_byte
);
  localparam int         OFS_W   = $clog2(N_AP*DESC_BYTES);
  localparam logic [7:0] TBL_END = 8'(N_AP*DESC_BYTES);
  localparam logic [7:0] LOCK_LO = 8'd2;
  localparam int         CNT_W   = $clog2(SETTLE_CYC+1);
  localparam int         SW      = 1 + 1 + 16 + 8;

  logic        phi_s, rw_s, phi_q;
  logic [15:0] addr_s;
  logic [7:0]  data_s;

  ap_bus_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .d   ({bus_phi2, bus_rw, bus_addr, bus_data}),
    .q   ({phi_s, rw_s, addr_s, data_s})
  );

  function automatic logic is_tbl(input logic [15:0] a);
    return (a[15:8] == IO_PAGE) && (a[7:0] < TBL_END) && (a[7:0] >= LOCK_LO);
  endfunction

  function automatic logic is_cmd(input logic [15:0] a);
    return (a[15:8] == IO_PAGE) && (a[7:0] == CMD_OFS);
  endfunction

  logic             fall;
  logic             arm, cyc_valid, cyc_rw;
  logic [CNT_W-1:0] cnt;
  logic [15:0]      cyc_addr;
  logic             tbl_we;
  logic [7:0]       tbl_rd;
  ap_desc_t         desc [N_AP];
  logic             map_hit;
  logic [31:0]      map_xlat;
  logic             hit_ok, rd_ok;

  assign fall   = phi_q & ~phi_s;
  assign tbl_we = fall && cyc_valid && !cyc_rw && is_tbl(cyc_addr);

  ap_desc_table #(.N_AP(N_AP)) u_tbl (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (tbl_we),
    .wr_ofs  (cyc_addr[OFS_W-1:0]),
    .wr_byte (data_s),
    .rd_ofs  (addr_s[OFS_W-1:0]),
    .rd_byte (tbl_rd),
    .desc_o  (desc)
  );

  ap_window_match #(.N_AP(N_AP)) u_match (
    .desc_i (desc),
    .page   (addr_s[15:8]),
    .low    (addr_s[7:0]),
    .hit    (map_hit),
    .xlat   (map_xlat)
  );

  assign hit_ok = map_hit && (addr_s[15:8] != IO_PAGE);
  assign rd_ok  = rw_s && is_tbl(addr_s);

  always_ff @(posedge clk) begin
    if (rst) begin
      phi_q        <= 1'b0;
      arm          <= 1'b0;
      cnt          <= '0;
      cyc_valid    <= 1'b0;
      cyc_rw       <= 1'b1;
      cyc_addr     <= '0;
      mpd_n        <= 1'b1;
      psram_addr   <= '0;
      psram_rd     <= 1'b0;
      psram_wr     <= 1'b0;
      host_data_oe <= 1'b0;
      host_rd_data <= '0;
      cmd_strobe   <= 1'b0;
      cmd_byte     <= '0;
    end else begin
      phi_q      <= phi_s;
      cmd_strobe <= 1'b0;
      if (fall) begin
        arm          <= 1'b1;
        cnt          <= CNT_W'(SETTLE_CYC);
        cyc_valid    <= 1'b0;
        mpd_n        <= 1'b1;
        psram_rd     <= 1'b0;
        psram_wr     <= 1'b0;
        host_data_oe <= 1'b0;
        if (cyc_valid && !cyc_rw && is_cmd(cyc_addr)) begin
          cmd_strobe <= 1'b1;
          cmd_byte   <= data_s;
        end
      end else if (arm) begin
        if (cnt == '0) begin
          arm          <= 1'b0;
          cyc_valid    <= 1'b1;
          cyc_addr     <= addr_s;
          cyc_rw       <= rw_s;
          mpd_n        <= ~hit_ok;
          psram_addr   <= hit_ok ? map_xlat : '0;
          psram_rd     <= hit_ok && rw_s;
          psram_wr     <= hit_ok && !rw_s;
          host_data_oe <= rd_ok;
          host_rd_data <= rd_ok ? tbl_rd : 8'd0;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ap_map_checker.sv
module ap_map_checker (
  input logic        clk,
  input logic        rst,
  input logic        mpd_n,
  input logic [31:0] psram_addr,
  input logic        psram_rd,
  input logic        psram_wr,
  input logic        host_data_oe,
  input logic        cmd_strobe
);
  assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mpd_n && !psram_rd && !psram_wr && !host_data_oe));

  assert_one_qual_on_hit_R7: assert property (@(posedge clk) disable iff (rst)
    !mpd_n |-> ($countones({psram_rd, psram_wr}) == 1));

  assert_qual_needs_hit_R7: assert property (@(posedge clk) disable iff (rst)
    (psram_rd || psram_wr) |-> !mpd_n);

  assert_no_drive_on_map_R9: assert property (@(posedge clk) disable iff (rst)
    !mpd_n |-> !host_data_oe);

  assert_cmd_single_R10: assert property (@(posedge clk) disable iff (rst)
    cmd_strobe |=> !cmd_strobe);

  assert_addr_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (!mpd_n && !$past(mpd_n)) |-> $stable(psram_addr));
endmodule

bind bus_aperture_map ap_map_checker u_chk (
  .clk          (clk),
  .rst          (rst),
  .mpd_n        (mpd_n),
  .psram_addr   (psram_addr),
  .psram_rd     (psram_rd),
  .psram_wr     (psram_wr),
  .host_data_oe (host_data_oe),
  .cmd_strobe   (cmd_strobe)
);

// File: tb/bus_aperture_map_test.sv
`timescale 1ns/1ps
module bus_aperture_map_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_phi2 = 1'b1;
  logic        bus_rw = 1'b1;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_data = '0;
  logic        mpd_n, psram_rd, psram_wr, host_data_oe, cmd_strobe;
  logic [31:0] psram_addr;
  logic [7:0]  host_rd_data, cmd_byte;

  always #2.5 clk = ~clk;

  bus_aperture_map uut (
    .clk(clk), .rst(rst), .bus_phi2(bus_phi2), .bus_rw(bus_rw),
    .bus_addr(bus_addr), .bus_data(bus_data), .mpd_n(mpd_n),
    .psram_addr(psram_addr), .psram_rd(psram_rd), .psram_wr(psram_wr),
    .host_data_oe(host_data_oe), .host_rd_data(host_rd_data),
    .cmd_strobe(cmd_strobe), .cmd_byte(cmd_byte)
  );

  typedef struct {
    logic        mpd_n;
    logic [31:0] pa;
    logic        rd, wr, oe;
    logic [7:0]  rdat;
  } exp_t;

  exp_t  q_exp [$];
  string q_tag [$];
  event  sample_ev;
  int    total = 0, bad = 0;
  logic [7:0] tbl_m [128];
  int    n_strobe = 0;
  logic [7:0] last_cmd = '0;
  bit    done = 0;

  always @(posedge clk) if (cmd_strobe) begin
    n_strobe++;
    last_cmd = cmd_byte;
  end

  function automatic bit wr_ok(input logic [15:0] a);
    return a[15:8] == 8'hD1 && a[7:0] < 8'h80 && a[7:0] >= 8'h02;
  endfunction

  function automatic exp_t predict(input logic [15:0] a, input logic rw);
    exp_t e;
    e.mpd_n = 1'b1; e.pa = '0; e.rd = 1'b0; e.wr = 1'b0; e.oe = 1'b0; e.rdat = '0;
    if (rw && wr_ok(a)) begin
      e.oe = 1'b1;
      e.rdat = tbl_m[a[6:0]];
    end
    if (a[15:8] != 8'hD1) begin
      for (int i = 15; i >= 0; i--) begin
        logic [7:0] st, ct;
        st = tbl_m[8*i+4];
        ct = tbl_m[8*i+5];
        if (ct != 0 && a[15:8] >= st && (int'(a[15:8]) - int'(st)) < int'(ct)) begin
          e.mpd_n = 1'b0;
          e.pa = {tbl_m[8*i+3], tbl_m[8*i+2], tbl_m[8*i+1], tbl_m[8*i]}
                 + {16'd0, 8'(a[15:8] - st), a[7:0]};
          e.rd = rw;
          e.wr = !rw;
        end
      end
    end
    return e;
  endfunction

  task automatic check(input bit ok, input string req, input string msg);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  // Monitor: pops expected items and compares them with the outputs.
  initial forever begin
    exp_t e;
    string tg;
    @(sample_ev);
    e  = q_exp.pop_front();
    tg = q_tag.pop_front();
    check(mpd_n == e.mpd_n && psram_rd == e.rd && psram_wr == e.wr &&
          host_data_oe == e.oe &&
          (e.mpd_n || psram_addr == e.pa) && (!e.oe || host_rd_data == e.rdat), tg,
          $sformatf("actual mpd_n=%0b pa=%h rd=%0b wr=%0b oe=%0b d=%h expected mpd_n=%0b pa=%h rd=%0b wr=%0b oe=%0b d=%h",
                    mpd_n, psram_addr, psram_rd, psram_wr, host_data_oe, host_rd_data,
                    e.mpd_n, e.pa, e.rd, e.wr, e.oe, e.rdat));
  end

  // Driver: one bus cycle starting at the CPU clock falling edge.
  task automatic bus_cyc(input logic [15:0] a, input logic rw, input logic [7:0] d,
                         input string tg);
    bus_phi2 = 1'b0;
    #40;
    check(mpd_n && !psram_rd && !psram_wr && !host_data_oe, "R11",
          $sformatf("early-cycle idle actual mpd_n=%0b rd=%0b wr=%0b oe=%0b expected 1 0 0 0",
                    mpd_n, psram_rd, psram_wr, host_data_oe));
    bus_addr = a;
    bus_rw   = rw;
    q_exp.push_back(predict(a, rw));
    q_tag.push_back(tg);
    #240 bus_phi2 = 1'b1;
    #20 if (!rw) bus_data = d;
    #120 -> sample_ev;
    #140;
    if (!rw && wr_ok(a)) tbl_m[a[6:0]] = d;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 128; i++) tbl_m[i] = 8'h00;
    repeat (10) @(posedge clk);
    #1 rst = 1'b0;
    #20;
    check(mpd_n && !psram_rd && !psram_wr && !host_data_oe && !cmd_strobe, "R1",
          $sformatf("reset state actual mpd_n=%0b rd=%0b wr=%0b oe=%0b expected 1 0 0 0",
                    mpd_n, psram_rd, psram_wr, host_data_oe));
    bus_cyc(16'h4000, 1, 0, "R1");
    bus_cyc(16'hD105, 1, 0, "R3");
    // window 1: base 0x00012300, pages $40..$43, stride 2
    bus_cyc(16'hD108, 0, 8'h00, "R2");
    bus_cyc(16'hD109, 0, 8'h23, "R2");
    bus_cyc(16'hD10A, 0, 8'h01, "R2");
    bus_cyc(16'hD10B, 0, 8'h00, "R2");
    bus_cyc(16'hD10C, 0, 8'h40, "R2");
    bus_cyc(16'hD10D, 0, 8'h04, "R2");
    bus_cyc(16'hD10E, 0, 8'h02, "R2");
    // window 0: locked low bytes, base 0x00050000, page $42 only
    bus_cyc(16'hD100, 0, 8'hFF, "R4");
    bus_cyc(16'hD101, 0, 8'hEE, "R4");
    bus_cyc(16'hD102, 0, 8'h05, "R2");
    bus_cyc(16'hD104, 0, 8'h42, "R2");
    bus_cyc(16'hD105, 0, 8'h01, "R2");
    // window 15: base 0x00800000, pages $D0..$D2
    bus_cyc(16'hD17A, 0, 8'h80, "R2");
    bus_cyc(16'hD17C, 0, 8'hD0, "R2");
    bus_cyc(16'hD17D, 0, 8'h03, "R2");
    bus_cyc(16'hD17F, 0, 8'h77, "R2");
    // read-back and ignored addresses
    bus_cyc(16'hD109, 1, 0, "R3");
    bus_cyc(16'hD10E, 1, 0, "R2");
    bus_cyc(16'hD17F, 1, 0, "R3");
    bus_cyc(16'hD100, 1, 0, "R4");
    bus_cyc(16'hD101, 1, 0, "R4");
    bus_cyc(16'hD180, 1, 0, "R4");
    bus_cyc(16'hD1B0, 1, 0, "R4");
    // mapping
    bus_cyc(16'h4000, 1, 0, "R5");
    bus_cyc(16'h4155, 0, 8'h11, "R7");
    bus_cyc(16'h42AA, 1, 0, "R8");
    bus_cyc(16'h43FF, 1, 0, "R6");
    bus_cyc(16'h4400, 1, 0, "R5");
    bus_cyc(16'h3FFF, 1, 0, "R5");
    bus_cyc(16'hD010, 1, 0, "R6");
    bus_cyc(16'hD1FF, 1, 0, "R9");
    bus_cyc(16'hD120, 1, 0, "R9");
    bus_cyc(16'hD205, 0, 8'h22, "R7");
    // command strobe
    bus_cyc(16'hD180, 0, 8'h5A, "R10");
    bus_cyc(16'hD181, 0, 8'h33, "R4");
    bus_cyc(16'h0000, 1, 0, "R10");
    check(n_strobe == 1 && last_cmd == 8'h5A, "R10",
          $sformatf("actual strobes=%0d byte=%h expected strobes=1 byte=5a", n_strobe, last_cmd));
    // disabling window 1 takes effect on the next cycle
    bus_cyc(16'hD10D, 0, 8'h00, "R2");
    bus_cyc(16'h4000, 1, 0, "R2");
    bus_cyc(16'h42AA, 0, 8'h44, "R8");
    bus_cyc(16'h0000, 1, 0, "R5");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule